// File: doc/BRIEF.md
# Shift and Rotate Unit with Status Flags

This block carries out the shift and rotate steps of an integer execution pipe on a single operand that is 8 or 16 bits wide. A request gives an operation code, the operand, a count and the incoming status flags (carry, overflow, sign, zero and parity). The unit then moves the operand by one bit position per clock until the count is used up. It returns the final value together with the updated flags and pulses `done` for one cycle. The count is either the fixed value 1 or an 8-bit value taken from an input, selected per request.

The supported operations are as follows. Left shift fills with zeros. Logical right shift fills with zeros. Arithmetic right shift copies the sign bit into the top. Plain rotates run in both directions. Rotates through carry, also in both directions, treat the carry flag as one extra bit of the ring. Shifts rewrite carry, sign, zero and parity. Rotates rewrite only carry and pass the other three through. Overflow is computed only for a count of one, and a separate qualifier output marks when it holds a defined value.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 0 (and the spare code 7) is a left shift. Each step moves every bit up one place and fills bit 0 with 0. `cf` takes the bit that left the top, so 0x1234 shifted by 1 gives 0x2468 with `cf`=0.
- R2: Operation code 1 is a logical right shift. Each step fills the top bit with 0, and `cf` holds the last bit that left bit 0, so 0x1234 shifted by 2 gives 0x048D with `cf`=0.
- R3: Operation code 2 is an arithmetic right shift. Each step copies the sign bit back into the top, and `cf` holds the last bit out of bit 0. For example, 0x091A by 2 gives 0x0246 with `cf`=1, and 0xFFA0 by 2 gives 0xFFE8.
- R4: Operation code 3 rotates left and code 4 rotates right. The bit leaving one end enters the other end and is also copied into `cf`, so 0x1234 rotated right by 4 gives 0x4123.
- R5: Operation code 5 rotates left through carry and code 6 rotates right through carry. The incoming carry enters the vacated end on the first step, and `cf` ends up holding the last bit out. With carry 0, 0x1234 gives 0x2340 with `cf`=1 when rotated left by 4, and 0x8123 with `cf`=0 when rotated right by 4.
- R6: After a shift (codes 0, 1, 2, 7) with a nonzero count, `sf` equals the top result bit and `zf` is 1 only when the result is zero. `pf` is 1 when the low byte of the result has an even number of 1 bits.
- R7: After a rotate (codes 3 to 6), `sf`, `zf` and `pf` equal the `sf_in`, `zf_in` and `pf_in` values sampled at start.
- R8: When the count is 1, `of_valid` is 1 at completion and `of` is set as follows. For codes 0, 7, 3 and 5 it is the top result bit XOR `cf`. For code 1 it is the original top bit. For code 2 it is 0. For codes 4 and 6 it is the XOR of the two top result bits. For any other count, `of_valid` is 0 and `of` keeps `of_in`.
- R9: The effective count is `count_in` when `cnt_sel` is 1, and 1 when `cnt_sel` is 0. A start accepted at one clock edge with an effective count N of 1 to 255 raises `busy` for N cycles. `done` is high for exactly one cycle, N edges after the accepting edge, with the final result and flags on the outputs.
- R10: An effective count of 0 raises `done` at the edge after start, without `busy`. The result then equals the operand, and `cf`, `of`, `sf`, `zf` and `pf` equal their inputs.
- R11: `start` is ignored while `busy` is high. The running operation ends at its original time with its original result.
- R12: After reset, `busy`, `done`, `result`, every flag and `of_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new operation when idle |
| op | input | 3 | Operation code (see R1 to R5) |
| operand | input | WIDTH | Value to be shifted or rotated |
| cnt_sel | input | 1 | 1: count from `count_in`; 0: count of one |
| count_in | input | 8 | Step count |
| cf_in | input | 1 | Incoming carry |
| of_in | input | 1 | Incoming overflow |
| sf_in | input | 1 | Incoming sign |
| zf_in | input | 1 | Incoming zero |
| pf_in | input | 1 | Incoming parity |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Operand after the last step |
| cf | output | 1 | Carry |
| of | output | 1 | Overflow |
| sf | output | 1 | Sign |
| zf | output | 1 | Zero |
| pf | output | 1 | Parity of the low byte |
| of_valid | output | 1 | `of` holds a defined value |

## Verification
The checker properties assume that `start` is never raised in the cycle where `done` is high. They also assume the operand and flag inputs are only of interest in the cycle a start is accepted. The stimulus respects both: every request is launched from an idle cycle after the previous `done` has dropped. The only mid-operation `start` pulses are the deliberate ones that test R11, and these carry a different operand and code so that any capture would show up in the result. Random requests mix all eight codes, both count sources, counts of 0, 1, small values and full 8-bit values, and random incoming flags.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] operand,
  input  logic             cnt_sel,
  input  logic [CNT_W-1:0] count_in,
  input  logic             cf_in,
  input  logic             of_in,
  input  logic             sf_in,
  input  logic             zf_in,
  input  logic             pf_in,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             cf,
  output logic             of,
  output logic             sf,
  output logic             zf,
  output logic             pf,
  output logic             of_valid
);
  localparam int MSB = WIDTH - 1;
  localparam logic [2:0] OP_SHL = 3'd0, OP_SHR = 3'd1, OP_SAR = 3'd2,
                         OP_ROL = 3'd3, OP_ROR = 3'd4, OP_RCL = 3'd5,
                         OP_RCR = 3'd6;

  logic [WIDTH-1:0] data_q, nxt_d;
  logic [CNT_W-1:0] rem_q, eff_cnt;
  logic [2:0]       op_q;
  logic             carry_q, nxt_c, one_q, msb0_q, busy_q, done_q;
  logic             of_q, sf_q, zf_q, pf_q, ofv_q, of_next, is_shift;

  assign eff_cnt  = cnt_sel ? count_in : CNT_W'(1);
  assign is_shift = (op_q == OP_SHR) || (op_q == OP_SAR) ||
                    (op_q == OP_SHL) || (op_q == 3'd7);

  always_comb begin
    case (op_q)
      OP_SHR:  begin nxt_d = {1'b0, data_q[MSB:1]};          nxt_c = data_q[0];   end
      OP_SAR:  begin nxt_d = {data_q[MSB], data_q[MSB:1]};   nxt_c = data_q[0];   end
      OP_ROL:  begin nxt_d = {data_q[MSB-1:0], data_q[MSB]}; nxt_c = data_q[MSB]; end
      OP_ROR:  begin nxt_d = {data_q[0], data_q[MSB:1]};     nxt_c = data_q[0];   end
      OP_RCL:  begin nxt_d = {data_q[MSB-1:0], carry_q};     nxt_c = data_q[MSB]; end
      OP_RCR:  begin nxt_d = {carry_q, data_q[MSB:1]};       nxt_c = data_q[0];   end
      default: begin nxt_d = {data_q[MSB-1:0], 1'b0};        nxt_c = data_q[MSB]; end
    endcase
  end

  always_comb begin
    case (op_q)
      OP_SHR:          of_next = msb0_q;
      OP_SAR:          of_next = 1'b0;
      OP_ROR, OP_RCR:  of_next = nxt_d[MSB] ^ nxt_d[MSB-1];
      default:         of_next = nxt_d[MSB] ^ nxt_c;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      carry_q <= 1'b0;
      rem_q   <= '0;
      op_q    <= OP_SHL;
      one_q   <= 1'b0;
      msb0_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      of_q    <= 1'b0;
      sf_q    <= 1'b0;
      zf_q    <= 1'b0;
      pf_q    <= 1'b0;
      ofv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          data_q  <= operand;
          carry_q <= cf_in;
          of_q    <= of_in;
          sf_q    <= sf_in;
          zf_q    <= zf_in;
          pf_q    <= pf_in;
          ofv_q   <= 1'b0;
          op_q    <= op;
          msb0_q  <= operand[MSB];
          one_q   <= (eff_cnt == CNT_W'(1));
          rem_q   <= eff_cnt;
          if (eff_cnt == '0) done_q <= 1'b1;
          else               busy_q <= 1'b1;
        end
      end else begin
        data_q  <= nxt_d;
        carry_q <= nxt_c;
        rem_q   <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          ofv_q  <= one_q;
          if (one_q) of_q <= of_next;
          if (is_shift) begin
            sf_q <= nxt_d[MSB];
            zf_q <= (nxt_d == '0);
            pf_q <= ~^nxt_d[7:0];
          end
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign result   = data_q;
  assign cf       = carry_q;
  assign of       = of_q;
  assign sf       = sf_q;
  assign zf       = zf_q;
  assign pf       = pf_q;
  assign of_valid = ofv_q;
endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] operand,
  input logic             cnt_sel,
  input logic [CNT_W-1:0] count_in,
  input logic             cf_in,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic             cf,
  input logic             of,
  input logic             sf,
  input logic             zf,
  input logic             pf,
  input logic             of_valid
);
  logic zero_req, run_req;
  assign zero_req = start && !busy && cnt_sel && (count_in == '0);
  assign run_req  = start && !busy && !(cnt_sel && (count_in == '0));

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);  // R9
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));  // R11
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    run_req |=> busy);  // R9
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (done && !busy && result == $past(operand) && cf == $past(cf_in)));  // R10
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({of, sf, zf, pf, of_valid}));  // R7
  AST_OFV_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && of_valid) |-> ($past(busy) && !$past(busy, 2)));  // R8
endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .cnt_sel(cnt_sel),
  .count_in(count_in), .cf_in(cf_in), .busy(busy), .done(done), .result(result),
  .cf(cf), .of(of), .sf(sf), .zf(zf), .pf(pf), .of_valid(of_valid)
);

// File: tb/shift_rotate_unit_bench.sv
`timescale 1ns/1ps
module shift_rotate_unit_bench;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op = '0;
  logic [W-1:0] operand = '0;
  logic cnt_sel = 1'b0;
  logic [7:0] count_in = '0;
  logic cf_in = 0, of_in = 0, sf_in = 0, zf_in = 0, pf_in = 0;
  logic busy, done, cf, of, sf, zf, pf, of_valid;
  logic [W-1:0] result;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  shift_rotate_unit #(.WIDTH(W)) u_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
    .cnt_sel(cnt_sel), .count_in(count_in), .cf_in(cf_in), .of_in(of_in),
    .sf_in(sf_in), .zf_in(zf_in), .pf_in(pf_in), .busy(busy), .done(done),
    .result(result), .cf(cf), .of(of), .sf(sf), .zf(zf), .pf(pf), .of_valid(of_valid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] o, input logic [W-1:0] d, input logic ci, input int n,
                       input logic oi, input logic si, input logic zi, input logic pi,
                       output logic [W-1:0] r, output logic c, output logic ov, output logic s,
                       output logic z, output logic p, output logic ovv);
    logic t;
    r = d; c = ci; ov = oi; s = si; z = zi; p = pi; ovv = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (o)
        3'd1: begin c = r[0]; r = r >> 1; end
        3'd2: begin c = r[0]; r = W'($signed(r) >>> 1); end
        3'd3: begin c = r[W-1]; r = (r << 1) | (r >> (W-1)); end
        3'd4: begin c = r[0]; r = (r >> 1) | (r << (W-1)); end
        3'd5: begin t = r[W-1]; r = (r << 1) | W'(c); c = t; end
        3'd6: begin t = r[0]; r = (r >> 1) | (W'(c) << (W-1)); c = t; end
        default: begin c = r[W-1]; r = r << 1; end
      endcase
    end
    if (n > 0 && (o <= 3'd2 || o == 3'd7)) begin
      s = r[W-1]; z = (r == 0);
      p = 1'b1;
      for (int b = 0; b < 8; b++) p = p ^ r[b];
    end
    if (n == 1) begin
      ovv = 1'b1;
      case (o)
        3'd1: ov = d[W-1];
        3'd2: ov = 1'b0;
        3'd4, 3'd6: ov = r[W-1] ^ r[W-2];
        default: ov = r[W-1] ^ c;
      endcase
    end
  endtask

  task automatic run(input string req, input logic [2:0] o, input logic [W-1:0] d, input logic sel,
                     input logic [7:0] cnt, input logic [4:0] fl, input bit inject);
    logic [W-1:0] er; logic ec, eo, es, ez, ep, ev;
    int n, lat;
    n = sel ? int'(cnt) : 1;
    model(o, d, fl[0], n, fl[1], fl[2], fl[3], fl[4], er, ec, eo, es, ez, ep, ev);
    op = o; operand = d; cnt_sel = sel; count_in = cnt;
    {pf_in, zf_in, sf_in, of_in, cf_in} = fl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req, "busy after start", 32'(busy), 32'(n > 0));
    lat = 0;
    while (!done && lat < 300) begin
      if (inject && lat == 1 && busy) begin
        start = 1'b1; operand = ~d; op = o ^ 3'd3; count_in = 8'd0;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(req, "latency", 32'(lat), 32'(n));
    chk(req, "result", 32'(result), 32'(er));
    chk(req, "cf", 32'(cf), 32'(ec));
    chk("R6/R7", "sf", 32'(sf), 32'(es));
    chk("R6/R7", "zf", 32'(zf), 32'(ez));
    chk("R6/R7", "pf", 32'(pf), 32'(ep));
    chk("R8", "of_valid", 32'(of_valid), 32'(ev));
    chk("R8", "of", 32'(of), 32'(eo));
    @(negedge clk);
    chk("R9", "done one cycle", 32'(done), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "reset state", {25'd0, busy, done, cf, of, sf, zf, pf, of_valid}, 32'd0);
    chk("R12", "reset result", 32'(result), 32'd0);

    run("R1", 3'd0, 16'h1234, 1'b0, 8'd9, 5'b00000, 0);
    run("R1", 3'd7, 16'h8001, 1'b1, 8'd1, 5'b00000, 0);
    run("R2", 3'd1, 16'h1234, 1'b1, 8'd2, 5'b00001, 0);
    run("R3", 3'd2, 16'h091A, 1'b1, 8'd2, 5'b00000, 0);
    run("R3", 3'd2, 16'hFFA0, 1'b1, 8'd2, 5'b00000, 0);
    run("R4", 3'd4, 16'h1234, 1'b1, 8'd4, 5'b11100, 0);
    run("R4", 3'd3, 16'h8001, 1'b1, 8'd1, 5'b00000, 0);
    run("R5", 3'd5, 16'h1234, 1'b1, 8'd4, 5'b00000, 0);
    run("R5", 3'd6, 16'h1234, 1'b1, 8'd4, 5'b00000, 0);
    run("R5", 3'd6, 16'h0001, 1'b1, 8'd1, 5'b00001, 0);
    run("R6", 3'd0, 16'h0080, 1'b1, 8'd9, 5'b11101, 0);
    run("R7", 3'd3, 16'h0000, 1'b1, 8'd3, 5'b10100, 0);
    run("R8", 3'd1, 16'h8000, 1'b0, 8'd0, 5'b00000, 0);
    run("R8", 3'd2, 16'hC000, 1'b1, 8'd1, 5'b00010, 0);
    run("R10", 3'd0, 16'hBEEF, 1'b1, 8'd0, 5'b10111, 0);
    run("R9", 3'd1, 16'hF00F, 1'b1, 8'd255, 5'b00000, 0);
    run("R11", 3'd0, 16'h00F1, 1'b1, 8'd5, 5'b00000, 1);
    run("R11", 3'd6, 16'h7A5C, 1'b1, 8'd2, 5'b00001, 1);

    for (int k = 0; k < 150; k++) begin
      logic [7:0] c;
      c = ($urandom % 10 == 0) ? 8'($urandom) : 8'($urandom % 20);
      run("R1-R8 random", 3'($urandom), W'($urandom), ($urandom % 4) != 0, c, 5'($urandom), k % 17 == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule